// File: doc/BRIEF.md
# Checksummed Serial Command Frame Receiver

This block takes command frames from a three-wire serial port (serial clock, serial data and a latch strobe) into the system clock domain. All three pins pass through two-flop synchronizers and edge detectors. The bit counter and the shift register are cleared when the latch rises. While the latch is high, each rising edge of the serial clock shifts in one data bit, least significant bit of the first byte first, until a 64-bit frame of eight bytes has been assembled.

When the latch falls, the receiver judges the frame. The frame must have exactly 64 bits, a legal header in byte 1 and a zero modulo-256 sum over all eight bytes. A frame that passes all three tests is committed:

- its payload bytes 2 to 7 go into the configuration store or the run-time store, chosen by the header;
- the four expansion bits from byte 1 drive the expansion outputs;
- for a run-time frame, a per-channel step-present flag is raised.

Every committed frame is also offered once on a valid/ready output stream. The payload and the frame type stay stable until the consumer accepts. If a frame completes while the previous offer is still waiting, the new frame is discarded. The status flags still report the discarded frame, but no store, output or step flag changes.

Top module: `cmd_frame_rx`

## Requirements
- R1: While rst_n is low at a clock edge, all stores, frm_data, frm_is_cfg, frm_valid, exp_out, frame_ok, csum_ok, step_a and step_b are cleared to 0.
- R2: Data is sampled on the rising serial-clock edges seen while the latch is high, least significant bit first. Frame bit i is byte (i/8)+1, bit i%8. frm_data[8*(k-2)+7 : 8*(k-2)] carries byte k for k = 2..7, and cfg_fields and run_fields use the same layout. Serial clock edges while the latch is low have no effect.
- R3: On each latch fall, frame_ok is set to 1 only if all three tests pass: exactly 64 bits were counted, byte 1 bits 7..5 are 111 or 000, and byte 1 bit 4 is 0. Otherwise frame_ok is 0 and the stores, exp_out and the stream are left unchanged.
- R4: On each latch fall, csum_ok is set to 1 only if exactly 64 bits were counted and the eight bytes sum to 00h modulo 256. Otherwise csum_ok is 0, and a frame with a bad sum is not committed.
- R5: A committed frame with header 111 loads bytes 2..7 into cfg_fields and is offered with frm_is_cfg = 1. With header 000 it loads run_fields and is offered with frm_is_cfg = 0. The other store keeps its value.
- R6: exp_out takes byte 1 bits 3..0 of each committed frame. A value of 0 means the pin sinks and 1 means it is released. exp_out is otherwise held.
- R7: step_a and step_b are cleared when the latch rises. On the latch fall, step_a is set to 1 only for a committed run-time frame with a nonzero byte 2 bits 5..0, and step_b only for one with a nonzero byte 5 bits 5..0. A bad checksum keeps both low.
- R8: frm_valid rises after each commit. frm_data and frm_is_cfg hold stable while frm_valid is high and frm_ready is low. A frame that completes in that state is discarded, with no change to the stores, exp_out, the stream or the step flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_latch | input | 1 | Frame window strobe, asynchronous |
| frm_ready | input | 1 | Consumer accepts the offered frame |
| frm_valid | output | 1 | A committed frame is offered |
| frm_is_cfg | output | 1 | Offered frame is a configuration frame |
| frm_data | output | 48 | Bytes 2..7 of the offered frame |
| cfg_fields | output | 48 | Bytes 2..7 of the last committed configuration frame |
| run_fields | output | 48 | Bytes 2..7 of the last committed run-time frame |
| exp_out | output | 4 | Expansion outputs, 0 = sink, 1 = released |
| frame_ok | output | 1 | Length and header of the last frame were legal |
| csum_ok | output | 1 | Sum of the last frame was zero |
| step_a | output | 1 | Channel A step-present flag |
| step_b | output | 1 | Channel B step-present flag |

## Verification
Some properties are checked by assertions on every cycle:

- the stream payload holds under back-pressure;
- the stores, the expansion outputs and the status flags move only on a latch fall, and only with good status;
- the step flags never stand high next to a bad checksum or a bad frame;
- the bit counter stays bounded.

The bench scenarios cover what needs known stimulus:

- least-significant-bit-first byte placement;
- rejection of short, long, empty and wrongly headed frames, with the stores intact;
- clock edges outside the latch window being ignored;
- a frame being dropped while an earlier one waits for acceptance.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

  typedef enum logic [1:0] {
    KIND_RUN = 2'd0,
    KIND_CFG = 2'd1,
    KIND_BAD = 2'd2
  } frame_kind_e;

  localparam logic [2:0] HDR_CFG = 3'b111;
  localparam logic [2:0] HDR_RUN = 3'b000;

  function automatic frame_kind_e decode_kind(input logic [7:0] first_byte);
    frame_kind_e k;
    if (first_byte[4])
      k = KIND_BAD;
    else if (first_byte[7:5] == HDR_CFG)
      k = KIND_CFG;
    else if (first_byte[7:5] == HDR_RUN)
      k = KIND_RUN;
    else
      k = KIND_BAD;
    return k;
  endfunction

endpackage

// File: rtl/frame_rx_sync.sv
module frame_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/frame_rx_shifter.sv
module frame_rx_shifter #(
  parameter int FRAME_BITS = 64,
  parameter int CNT_W      = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  win_open,
  input  logic                  win_start,
  input  logic                  bit_strobe,
  input  logic                  bit_val,
  output logic [FRAME_BITS-1:0] frame,
  output logic [CNT_W-1:0]      bit_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame   <= '0;
      bit_cnt <= '0;
    end else if (win_start) begin
      frame   <= '0;
      bit_cnt <= '0;
    end else if (win_open && bit_strobe) begin
      frame <= {bit_val, frame[FRAME_BITS-1:1]};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/frame_rx_commit.sv
module frame_rx_commit
  import frame_rx_pkg::*;
#(
  parameter int FRAME_BYTES = 8,
  parameter int FRAME_BITS  = 64,
  parameter int CNT_W       = 7,
  parameter int FIELD_W     = 48,
  parameter int STEP_W      = 6,
  parameter int A_BYTE      = 1,
  parameter int B_BYTE      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  win_start,
  input  logic                  win_end,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic [CNT_W-1:0]      bit_cnt,
  input  logic                  frm_ready,
  output logic                  frm_valid,
  output logic                  frm_is_cfg,
  output logic [FIELD_W-1:0]    frm_data,
  output logic [FIELD_W-1:0]    cfg_fields,
  output logic [FIELD_W-1:0]    run_fields,
  output logic [3:0]            exp_out,
  output logic                  frame_ok,
  output logic                  csum_ok,
  output logic                  step_a,
  output logic                  step_b
);

  logic [7:0]  byte_sum;
  frame_kind_e kind;
  logic        len_ok, hdr_ok, sum_ok, slot_free, do_commit, is_run;
  logic        a_nz, b_nz;

  always_comb begin
    byte_sum = 8'h00;
    for (int i = 0; i < FRAME_BYTES; i++)
      byte_sum = byte_sum + frame[i*8 +: 8];
  end

  assign kind      = decode_kind(frame[7:0]);
  assign len_ok    = (bit_cnt == CNT_W'(FRAME_BITS));
  assign hdr_ok    = (kind != KIND_BAD);
  assign sum_ok    = len_ok && (byte_sum == 8'h00);
  assign slot_free = !frm_valid || frm_ready;
  assign do_commit = win_end && len_ok && hdr_ok && sum_ok && slot_free;
  assign is_run    = (kind == KIND_RUN);
  assign a_nz      = |frame[A_BYTE*8 +: STEP_W];
  assign b_nz      = |frame[B_BYTE*8 +: STEP_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_valid  <= 1'b0;
      frm_is_cfg <= 1'b0;
      frm_data   <= '0;
      cfg_fields <= '0;
      run_fields <= '0;
      exp_out    <= 4'h0;
      frame_ok   <= 1'b0;
      csum_ok    <= 1'b0;
      step_a     <= 1'b0;
      step_b     <= 1'b0;
    end else begin
      if (frm_valid && frm_ready) frm_valid <= 1'b0;
      if (win_start) begin
        step_a <= 1'b0;
        step_b <= 1'b0;
      end
      if (win_end) begin
        frame_ok <= len_ok && hdr_ok;
        csum_ok  <= sum_ok;
        step_a   <= do_commit && is_run && a_nz;
        step_b   <= do_commit && is_run && b_nz;
      end
      if (do_commit) begin
        frm_valid  <= 1'b1;
        frm_is_cfg <= !is_run;
        frm_data   <= frame[8 +: FIELD_W];
        exp_out    <= frame[3:0];
        if (is_run) run_fields <= frame[8 +: FIELD_W];
        else        cfg_fields <= frame[8 +: FIELD_W];
      end
    end
  end

endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx #(
  parameter int FRAME_BYTES = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STEP_W      = 6,
  parameter int A_BYTE      = 1,
  parameter int B_BYTE      = 4,
  localparam int FRAME_BITS = FRAME_BYTES * 8,
  localparam int FIELD_W    = (FRAME_BYTES - 2) * 8,
  localparam int CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_latch,
  input  logic               frm_ready,
  output logic               frm_valid,
  output logic               frm_is_cfg,
  output logic [FIELD_W-1:0] frm_data,
  output logic [FIELD_W-1:0] cfg_fields,
  output logic [FIELD_W-1:0] run_fields,
  output logic [3:0]         exp_out,
  output logic               frame_ok,
  output logic               csum_ok,
  output logic               step_a,
  output logic               step_b
);

  logic [2:0]            pin_lvl, pin_rise, pin_fall;
  logic                  lat_rise, lat_fall, sclk_rise;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      bit_cnt;
  logic [2:0]            unused_edges;

  frame_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_latch, ser_data, ser_clk}),
    .lvl      (pin_lvl),
    .rise     (pin_rise),
    .fall     (pin_fall)
  );

  assign sclk_rise    = pin_rise[0];
  assign lat_rise     = pin_rise[2];
  assign lat_fall     = pin_fall[2];
  assign unused_edges = {pin_fall[1:0], pin_rise[1]};

  frame_rx_shifter #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_open   (pin_lvl[2]),
    .win_start  (lat_rise),
    .bit_strobe (sclk_rise),
    .bit_val    (pin_lvl[1]),
    .frame      (frame),
    .bit_cnt    (bit_cnt)
  );

  frame_rx_commit #(
    .FRAME_BYTES (FRAME_BYTES),
    .FRAME_BITS  (FRAME_BITS),
    .CNT_W       (CNT_W),
    .FIELD_W     (FIELD_W),
    .STEP_W      (STEP_W),
    .A_BYTE      (A_BYTE),
    .B_BYTE      (B_BYTE)
  ) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_start  (lat_rise),
    .win_end    (lat_fall),
    .frame      (frame),
    .bit_cnt    (bit_cnt),
    .frm_ready  (frm_ready),
    .frm_valid  (frm_valid),
    .frm_is_cfg (frm_is_cfg),
    .frm_data   (frm_data),
    .cfg_fields (cfg_fields),
    .run_fields (run_fields),
    .exp_out    (exp_out),
    .frame_ok   (frame_ok),
    .csum_ok    (csum_ok),
    .step_a     (step_a),
    .step_b     (step_b)
  );

endmodule

// File: rtl/cmd_frame_rx_chk.sv
module cmd_frame_rx_chk #(
  parameter int FIELD_W    = 48,
  parameter int CNT_W      = 7,
  parameter int FRAME_BITS = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lat_fall,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic               frm_valid,
  input logic               frm_ready,
  input logic               frm_is_cfg,
  input logic [FIELD_W-1:0] frm_data,
  input logic [FIELD_W-1:0] cfg_fields,
  input logic [FIELD_W-1:0] run_fields,
  input logic [3:0]         exp_out,
  input logic               frame_ok,
  input logic               csum_ok,
  input logic               step_a,
  input logic               step_b
);

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_data) && $stable(frm_is_cfg))); // R8

  AST_CSUM_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(csum_ok) |-> $past(lat_fall)); // R4

  AST_OK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_ok) |-> $past(lat_fall)); // R3

  AST_CFG_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_fields) |-> ($past(lat_fall) && frame_ok && csum_ok && frm_valid && frm_is_cfg)); // R5

  AST_RUN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run_fields) |-> ($past(lat_fall) && frame_ok && csum_ok && frm_valid && !frm_is_cfg)); // R5

  AST_EXP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(exp_out) |-> ($past(lat_fall) && frame_ok && csum_ok)); // R6

  AST_STEP_NEEDS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (step_a || step_b) |-> (csum_ok && frame_ok)); // R7

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS + 1)); // R3

endmodule

bind cmd_frame_rx cmd_frame_rx_chk #(
  .FIELD_W    (FIELD_W),
  .CNT_W      (CNT_W),
  .FRAME_BITS (FRAME_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lat_fall   (lat_fall),
  .bit_cnt    (bit_cnt),
  .frm_valid  (frm_valid),
  .frm_ready  (frm_ready),
  .frm_is_cfg (frm_is_cfg),
  .frm_data   (frm_data),
  .cfg_fields (cfg_fields),
  .run_fields (run_fields),
  .exp_out    (exp_out),
  .frame_ok   (frame_ok),
  .csum_ok    (csum_ok),
  .step_a     (step_a),
  .step_b     (step_b)
);

// File: tb/tb_cmd_frame_rx.sv
module tb_cmd_frame_rx;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
  logic        frm_ready = 1'b1;
  logic        frm_valid, frm_is_cfg, frame_ok, csum_ok, step_a, step_b;
  logic [47:0] frm_data, cfg_fields, run_fields;
  logic [3:0]  exp_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [48:0] sb_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_latch(ser_latch), .frm_ready(frm_ready), .frm_valid(frm_valid),
    .frm_is_cfg(frm_is_cfg), .frm_data(frm_data), .cfg_fields(cfg_fields),
    .run_fields(run_fields), .exp_out(exp_out), .frame_ok(frame_ok),
    .csum_ok(csum_ok), .step_a(step_a), .step_b(step_b)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] mkframe(input logic [55:0] lo);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < 7; i++) s = s + lo[i*8 +: 8];
    return {8'h00 - s, lo};
  endfunction

  task automatic send_bits(input logic [71:0] f, input int n);
    ser_latch = 1'b1;
    tick(4);
    for (int i = 0; i < n; i++) begin
      ser_data = f[i];
      ser_clk  = 1'b0;
      tick(4);
      ser_clk  = 1'b1;
      tick(4);
    end
    ser_clk = 1'b0;
    tick(4);
    ser_latch = 1'b0;
    tick(10);
  endtask

  // driver: pushes the expected stream item, then sends the frame
  task automatic drive(input logic [63:0] f, input bit commit);
    if (commit) sb_q.push_back({(f[7:5] == 3'b111), f[55:8]});
    send_bits({8'h00, f}, 64);
  endtask

  // monitor: compares every accepted stream item against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && frm_valid && frm_ready) begin
        if (sb_q.size() == 0) begin
          chk("R8 unexpected stream item", {15'h0, frm_is_cfg, frm_data}, 64'h0);
        end else begin
          logic [48:0] e;
          e = sb_q.pop_front();
          chk("R5 stream item", {15'h0, frm_is_cfg, frm_data}, {15'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [63:0] f_cfg, f_cfg2, f_r1, f_r2, f_bad, f_hdr, f_d4;

  initial begin
    f_cfg  = mkframe({8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'hEA});
    f_cfg2 = mkframe({8'hF6, 8'hE5, 8'hD4, 8'hC3, 8'hB2, 8'hA1, 8'hE6});
    f_r1   = mkframe({8'h78, 8'h56, 8'hC0, 8'h34, 8'h12, 8'h85, 8'h05});
    f_r2   = mkframe({8'h04, 8'h03, 8'h7F, 8'h02, 8'h01, 8'h40, 8'h03});
    f_bad  = f_r2 ^ 64'h0100_0000_0000_0000;
    f_hdr  = mkframe({8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'hA0});
    f_d4   = mkframe({8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h10});

    tick(5);
    // R1: reset state
    chk("R1 frm_valid", 64'(frm_valid), 64'h0);
    chk("R1 exp_out", 64'(exp_out), 64'h0);
    chk("R1 stores", 64'(cfg_fields | run_fields | frm_data), 64'h0);
    chk("R1 status", 64'({frame_ok, csum_ok, step_a, step_b}), 64'h0);
    rst_n = 1'b1;
    tick(4);

    // R2: clock edges with latch low are ignored
    ser_data = 1'b1;
    for (int i = 0; i < 6; i++) begin
      ser_clk = 1'b1; tick(4); ser_clk = 1'b0; tick(4);
    end
    chk("R2 no status change with latch low", 64'({frame_ok, csum_ok}), 64'h0);

    // R5 R2: configuration frame
    drive(f_cfg, 1);
    chk("R2 cfg_fields byte order", 64'(cfg_fields), 64'(f_cfg[55:8]));
    chk("R5 run_fields untouched", 64'(run_fields), 64'h0);
    chk("R6 exp_out from cfg", 64'(exp_out), 64'hA);
    chk("R3 frame_ok", 64'(frame_ok), 64'h1);
    chk("R4 csum_ok", 64'(csum_ok), 64'h1);
    chk("R7 no steps on cfg", 64'({step_a, step_b}), 64'h0);

    // R5 R7: run-time frame, channel A only
    drive(f_r1, 1);
    chk("R5 run_fields", 64'(run_fields), 64'(f_r1[55:8]));
    chk("R5 cfg_fields kept", 64'(cfg_fields), 64'(f_cfg[55:8]));
    chk("R6 exp_out from run", 64'(exp_out), 64'h5);
    chk("R7 step flags a", 64'({step_a, step_b}), 64'h2);

    // R7: cleared at latch rise (empty window, also R3)
    ser_latch = 1'b1;
    tick(6);
    chk("R7 step cleared on latch rise", 64'({step_a, step_b}), 64'h0);
    ser_latch = 1'b0;
    tick(10);
    chk("R3 empty frame invalid", 64'({frame_ok, csum_ok}), 64'h0);

    // R4: bad checksum
    drive(f_bad, 0);
    chk("R4 csum_ok low", 64'(csum_ok), 64'h0);
    chk("R3 frame_ok on bad sum", 64'(frame_ok), 64'h1);
    chk("R4 run_fields kept", 64'(run_fields), 64'(f_r1[55:8]));
    chk("R6 exp_out kept on bad sum", 64'(exp_out), 64'h5);
    chk("R7 no steps on bad sum", 64'({step_a, step_b}), 64'h0);

    // R3: short, long, illegal header, D4 set
    send_bits({8'h00, f_cfg2}, 63);
    chk("R3 short frame", 64'(frame_ok), 64'h0);
    chk("R3 short cfg kept", 64'(cfg_fields), 64'(f_cfg[55:8]));
    send_bits({8'h00, f_cfg2}, 65);
    chk("R3 long frame", 64'(frame_ok), 64'h0);
    chk("R3 long cfg kept", 64'(cfg_fields), 64'(f_cfg[55:8]));
    send_bits({8'h00, f_hdr}, 64);
    chk("R3 illegal header", 64'({frame_ok, csum_ok}), 64'h1);
    chk("R6 exp kept on illegal header", 64'(exp_out), 64'h5);
    send_bits({8'h00, f_d4}, 64);
    chk("R3 bit4 set", 64'(frame_ok), 64'h0);
    chk("R3 stores kept", 64'(run_fields), 64'(f_r1[55:8]));

    // R7: run frame, channel B only
    drive(f_r2, 1);
    chk("R7 step flags b", 64'({step_a, step_b}), 64'h1);
    chk("R6 exp_out r2", 64'(exp_out), 64'h3);

    // R8: back-pressure and drop
    frm_ready = 1'b0;
    drive(f_r1, 1);
    tick(20);
    chk("R8 valid held", 64'(frm_valid), 64'h1);
    chk("R8 data held", 64'(frm_data), 64'(f_r1[55:8]));
    drive(f_cfg2, 0);
    chk("R8 dropped frame status", 64'({frame_ok, csum_ok}), 64'h3);
    chk("R8 cfg not updated", 64'(cfg_fields), 64'(f_cfg[55:8]));
    chk("R8 exp not updated", 64'(exp_out), 64'h5);
    chk("R8 still offering first", 64'({frm_valid, frm_is_cfg}), 64'h2);
    frm_ready = 1'b1;
    tick(4);
    chk("R8 valid drops after accept", 64'(frm_valid), 64'h0);
    chk("R8 scoreboard drained", 64'(sb_q.size()), 64'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule